// File: doc/BRIEF.md
# Two-Stage Watchdog Timer Core

This block is a watchdog counter built as two cascaded countdown stages that run on a 33 MHz reference clock. When software enables it, the first stage is loaded from a first preload register and counts down. If nothing services the watchdog before that stage runs out, the block raises a one-cycle interrupt pulse on one of two lines, chosen by a type field. It then loads the second preload and counts again. If the second stage also runs out, the block issues a one-cycle reboot request and sets a sticky "last reset came from the watchdog" flag. A keep-alive strobe sends the counter back to a fresh first stage.

Each stage lasts the 20-bit preload shifted left by a fixed amount, counted in reference clock cycles. The shift is 15 bits in the coarse (about 1 kHz) setting and 5 bits in the fine (about 1 MHz) setting. The shift is applied when the stage is loaded. A free-running option restarts the first stage after the second stage expires. A lock bit freezes the enable, free-run and lock settings until the next reset. Address decoding belongs to the surrounding bus logic. This core only sees write strobes with their data.

Top module: `wdt2_core`

## Requirements
- R1: After reset, all pulse outputs and `last_wd_reset` are 0. Both preloads hold 0xFFFFF. The watchdog is disabled and unlocked, free-run is off, reboot is enabled, the coarse prescale is selected and the interrupt type is 0.
- R2: A stage lasts D = preload << 15 cycles when `cfg_fast` = 0 and D = preload << 5 cycles when `cfg_fast` = 1. A preload of 0 gives D = 1. The counter never holds 0 while it runs.
- R3: A control write that takes enable from 0 to 1 starts stage 1. If that write is captured at clock edge E, stage 1 expires at edge E + D1, and its pulse can be seen in the cycle after that edge.
- R4: A control write with enable = 0 on an unlocked core stops the counter, and no further pulse appears.
- R5: When stage 1 expires, the core emits a one-cycle pulse chosen by the type field. Type 0 gives `irq_pulse`, type 2 gives `smi_pulse`, and types 1 and 3 give no pulse. Stage 2 starts on the same edge with the second preload.
- R6: When stage 2 expires and `cfg_no_reboot` = 0, the core pulses `reboot_req` for one cycle, sets `last_wd_reset`, and stops counting unless free-run is set.
- R7: When stage 2 expires and `cfg_no_reboot` = 1, there is no reboot pulse and the flag is unchanged. The counter stops unless free-run is set.
- R8: With free-run set, stage 2 expiry restarts stage 1 with the first preload.
- R9: Once a control write sets lock = 1, later control writes change neither enable, nor free-run, nor lock until reset.
- R10: A keep-alive strobe while the watchdog is enabled reloads stage 1 with the full first preload. This happens even after a reboot has stopped the counter. A keep-alive takes priority over an expiry in the same cycle.
- R11: A keep-alive strobe while the watchdog is disabled has no effect.
- R12: `flag_clr` clears `last_wd_reset`. If a reboot event falls in the same cycle, the flag stays set.
- R13: `irq_pulse`, `smi_pulse` and `reboot_req` are registered single-cycle pulses, and at most one of them is high at a time.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | 33 MHz reference clock |
| rst | input | 1 | Synchronous active-high reset |
| ctl_we | input | 1 | Write strobe for the enable/lock/free-run group |
| ctl_en | input | 1 | Enable value for a control write |
| ctl_lock | input | 1 | Lock value for a control write |
| ctl_free | input | 1 | Free-run value for a control write |
| cfg_we | input | 1 | Write strobe for the configuration group |
| cfg_no_reboot | input | 1 | 1 disables the reboot request (active-low enable) |
| cfg_fast | input | 1 | 1 selects the fine prescale (shift 5), 0 the coarse one (shift 15) |
| cfg_int_type | input | 2 | Stage 1 interrupt type: 0 IRQ, 2 SMI, 1 or 3 none |
| pl1_we | input | 1 | Write strobe for the first preload |
| pl2_we | input | 1 | Write strobe for the second preload |
| pl_data | input | 20 | Preload write data |
| keepalive | input | 1 | Keep-alive strobe |
| flag_clr | input | 1 | Clears the previous-reboot flag |
| irq_pulse | output | 1 | Stage 1 expiry pulse, IRQ type |
| smi_pulse | output | 1 | Stage 1 expiry pulse, SMI type |
| reboot_req | output | 1 | Stage 2 expiry reboot request pulse |
| last_wd_reset | output | 1 | Sticky flag: the watchdog requested a reboot |

## Verification
The hardest situations to reach are races on a single clock edge. One is a keep-alive that arrives exactly on the edge where stage 1 would expire. Another is a flag clear that lands on the same edge as a reboot event. The bench keeps a cycle index and computes the expiry edge from the preload and the prescale. It then places the strobe on the negative edge just before that edge. Short preloads in fine mode, including a preload of zero, keep the whole chain within a few hundred cycles. A single coarse-mode run confirms the 15-bit shift.

// File: rtl/wdt2_pkg.sv
package wdt2_pkg;

  typedef enum logic [1:0] {
    INT_IRQ  = 2'd0,
    INT_RSVD = 2'd1,
    INT_SMI  = 2'd2,
    INT_NONE = 2'd3
  } int_sel_e;

  typedef enum logic {
    ST_ONE = 1'b0,
    ST_TWO = 1'b1
  } stage_e;

  typedef struct packed {
    logic en;
    logic lock;
    logic free;
  } ctl_t;

  typedef struct packed {
    logic     no_reboot;
    logic     fast;
    int_sel_e isel;
  } cfg_t;

endpackage

// File: rtl/wdt2_regs.sv
module wdt2_regs
  import wdt2_pkg::*;
#(
  parameter int PW = 20
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          ctl_we,
  input  ctl_t          ctl_d,
  input  logic          cfg_we,
  input  cfg_t          cfg_d,
  input  logic          pl1_we,
  input  logic          pl2_we,
  input  logic [PW-1:0] pl_d,
  output logic          en_q,
  output logic          free_q,
  output cfg_t          cfg_q,
  output logic [PW-1:0] pl1_q,
  output logic [PW-1:0] pl2_q,
  output logic          start,
  output logic          stop
);

  logic lock_q;
  logic ctl_ok;

  assign ctl_ok = ctl_we && !lock_q;
  assign start  = ctl_ok && ctl_d.en && !en_q;
  assign stop   = ctl_ok && !ctl_d.en;

  always_ff @(posedge clk) begin
    if (rst) begin
      en_q   <= 1'b0;
      lock_q <= 1'b0;
      free_q <= 1'b0;
    end else if (ctl_ok) begin
      en_q   <= ctl_d.en;
      lock_q <= ctl_d.lock;
      free_q <= ctl_d.free;
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      cfg_q.no_reboot <= 1'b0;
      cfg_q.fast      <= 1'b0;
      cfg_q.isel      <= INT_IRQ;
    end else if (cfg_we) begin
      cfg_q <= cfg_d;
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      pl1_q <= '1;
      pl2_q <= '1;
    end else begin
      if (pl1_we) pl1_q <= pl_d;
      if (pl2_we) pl2_q <= pl_d;
    end
  end

  // R9
  lock_hold_chk: assert property (@(posedge clk) disable iff (rst)
    lock_q |=> (lock_q && $stable(en_q) && $stable(free_q)));

endmodule

// File: rtl/wdt2_count.sv
module wdt2_count
  import wdt2_pkg::*;
#(
  parameter int PW       = 20,
  parameter int SLOW_SH  = 15,
  parameter int FAST_SH  = 5
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          en_q,
  input  logic          free_q,
  input  logic          no_reboot,
  input  logic          fast,
  input  logic [PW-1:0] pl1,
  input  logic [PW-1:0] pl2,
  input  logic          start,
  input  logic          stop,
  input  logic          kick,
  output logic          ev_s1,
  output logic          ev_reboot
);

  localparam int MAXSH = (SLOW_SH > FAST_SH) ? SLOW_SH : FAST_SH;
  localparam int CW    = PW + MAXSH;

  logic          run_q;
  stage_e        stage_q;
  logic [CW-1:0] cnt_q;
  logic          restart;
  logic          expire;
  logic          act;
  logic          ev_s2;

  function automatic logic [CW-1:0] stage_len(input logic [PW-1:0] p, input logic f);
    logic [CW-1:0] w;
    w = CW'(p);
    if (p == '0) return CW'(1);
    return f ? (w << FAST_SH) : (w << SLOW_SH);
  endfunction

  assign restart   = start || (kick && en_q);
  assign expire    = run_q && (cnt_q == CW'(1));
  assign act       = expire && !stop && !restart;
  assign ev_s1     = act && (stage_q == ST_ONE);
  assign ev_s2     = act && (stage_q == ST_TWO);
  assign ev_reboot = ev_s2 && !no_reboot;

  always_ff @(posedge clk) begin
    if (rst) begin
      run_q   <= 1'b0;
      stage_q <= ST_ONE;
      cnt_q   <= '0;
    end else if (stop) begin
      run_q   <= 1'b0;
      stage_q <= ST_ONE;
    end else if (restart) begin
      run_q   <= 1'b1;
      stage_q <= ST_ONE;
      cnt_q   <= stage_len(pl1, fast);
    end else if (ev_s1) begin
      stage_q <= ST_TWO;
      cnt_q   <= stage_len(pl2, fast);
    end else if (ev_s2) begin
      stage_q <= ST_ONE;
      if (free_q) cnt_q <= stage_len(pl1, fast);
      else        run_q <= 1'b0;
    end else if (run_q) begin
      cnt_q <= cnt_q - CW'(1);
    end
  end

  // R4
  idle_when_off_chk: assert property (@(posedge clk) disable iff (rst)
    !en_q |-> !run_q);

  // R2
  cnt_nonzero_chk: assert property (@(posedge clk) disable iff (rst)
    run_q |-> (cnt_q != '0));

endmodule

// File: rtl/wdt2_events.sv
module wdt2_events
  import wdt2_pkg::*;
(
  input  logic     clk,
  input  logic     rst,
  input  logic     ev_s1,
  input  logic     ev_reboot,
  input  int_sel_e isel,
  input  logic     flag_clr,
  output logic     irq_o,
  output logic     smi_o,
  output logic     reboot_o,
  output logic     flag_o
);

  always_ff @(posedge clk) begin
    if (rst) begin
      irq_o    <= 1'b0;
      smi_o    <= 1'b0;
      reboot_o <= 1'b0;
      flag_o   <= 1'b0;
    end else begin
      irq_o    <= ev_s1 && (isel == INT_IRQ);
      smi_o    <= ev_s1 && (isel == INT_SMI);
      reboot_o <= ev_reboot;
      if (ev_reboot)     flag_o <= 1'b1;
      else if (flag_clr) flag_o <= 1'b0;
    end
  end

  // R13
  pulse_excl_chk: assert property (@(posedge clk) disable iff (rst)
    $onehot0({irq_o, smi_o, reboot_o}));

  // R13
  irq_single_chk: assert property (@(posedge clk) disable iff (rst)
    (irq_o || smi_o) |=> !(irq_o || smi_o));

  // R6
  flag_follows_chk: assert property (@(posedge clk) disable iff (rst)
    reboot_o |-> flag_o);

  // R12
  flag_clr_chk: assert property (@(posedge clk) disable iff (rst)
    (flag_clr && !ev_reboot) |=> !flag_o);

endmodule

// File: rtl/wdt2_core.sv
module wdt2_core
  import wdt2_pkg::*;
#(
  parameter int PW      = 20,
  parameter int SLOW_SH = 15,
  parameter int FAST_SH = 5
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          ctl_we,
  input  logic          ctl_en,
  input  logic          ctl_lock,
  input  logic          ctl_free,
  input  logic          cfg_we,
  input  logic          cfg_no_reboot,
  input  logic          cfg_fast,
  input  logic [1:0]    cfg_int_type,
  input  logic          pl1_we,
  input  logic          pl2_we,
  input  logic [PW-1:0] pl_data,
  input  logic          keepalive,
  input  logic          flag_clr,
  output logic          irq_pulse,
  output logic          smi_pulse,
  output logic          reboot_req,
  output logic          last_wd_reset
);

  ctl_t          ctl_d;
  cfg_t          cfg_d;
  cfg_t          cfg_q;
  logic          en_q;
  logic          free_q;
  logic [PW-1:0] pl1_q;
  logic [PW-1:0] pl2_q;
  logic          start;
  logic          stop;
  logic          ev_s1;
  logic          ev_reboot;

  assign ctl_d.en        = ctl_en;
  assign ctl_d.lock      = ctl_lock;
  assign ctl_d.free      = ctl_free;
  assign cfg_d.no_reboot = cfg_no_reboot;
  assign cfg_d.fast      = cfg_fast;
  assign cfg_d.isel      = int_sel_e'(cfg_int_type);

  wdt2_regs #(.PW(PW)) u_regs (
    .clk    (clk),
    .rst    (rst),
    .ctl_we (ctl_we),
    .ctl_d  (ctl_d),
    .cfg_we (cfg_we),
    .cfg_d  (cfg_d),
    .pl1_we (pl1_we),
    .pl2_we (pl2_we),
    .pl_d   (pl_data),
    .en_q   (en_q),
    .free_q (free_q),
    .cfg_q  (cfg_q),
    .pl1_q  (pl1_q),
    .pl2_q  (pl2_q),
    .start  (start),
    .stop   (stop)
  );

  wdt2_count #(.PW(PW), .SLOW_SH(SLOW_SH), .FAST_SH(FAST_SH)) u_count (
    .clk       (clk),
    .rst       (rst),
    .en_q      (en_q),
    .free_q    (free_q),
    .no_reboot (cfg_q.no_reboot),
    .fast      (cfg_q.fast),
    .pl1       (pl1_q),
    .pl2       (pl2_q),
    .start     (start),
    .stop      (stop),
    .kick      (keepalive),
    .ev_s1     (ev_s1),
    .ev_reboot (ev_reboot)
  );

  wdt2_events u_events (
    .clk       (clk),
    .rst       (rst),
    .ev_s1     (ev_s1),
    .ev_reboot (ev_reboot),
    .isel      (cfg_q.isel),
    .flag_clr  (flag_clr),
    .irq_o     (irq_pulse),
    .smi_o     (smi_pulse),
    .reboot_o  (reboot_req),
    .flag_o    (last_wd_reset)
  );

endmodule

// File: tb/wdt2_core_tb_top.sv
module wdt2_core_tb_top;

  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        ctl_we = 0, ctl_en = 0, ctl_lock = 0, ctl_free = 0;
  logic        cfg_we = 0, cfg_no_reboot = 0, cfg_fast = 0;
  logic [1:0]  cfg_int_type = 0;
  logic        pl1_we = 0, pl2_we = 0;
  logic [19:0] pl_data = 0;
  logic        keepalive = 0, flag_clr = 0;
  logic        irq_pulse, smi_pulse, reboot_req, last_wd_reset;

  longint cyc = 0;
  longint wr_cyc = 0;
  int     n_chk = 0, n_err = 0;
  int     n_irq = 0, n_smi = 0, n_rb = 0, n_bad = 0;
  longint t_irq = -1, t_smi = -1, t_rb = -1;
  int     b_irq, b_smi, b_rb;
  logic   p_irq = 0, p_smi = 0, p_rb = 0;

  always #4 clk = ~clk;

  wdt2_core dut_i (
    .clk(clk), .rst(rst),
    .ctl_we(ctl_we), .ctl_en(ctl_en), .ctl_lock(ctl_lock), .ctl_free(ctl_free),
    .cfg_we(cfg_we), .cfg_no_reboot(cfg_no_reboot), .cfg_fast(cfg_fast),
    .cfg_int_type(cfg_int_type),
    .pl1_we(pl1_we), .pl2_we(pl2_we), .pl_data(pl_data),
    .keepalive(keepalive), .flag_clr(flag_clr),
    .irq_pulse(irq_pulse), .smi_pulse(smi_pulse), .reboot_req(reboot_req),
    .last_wd_reset(last_wd_reset)
  );

  always @(posedge clk) cyc <= cyc + 1;

  always @(negedge clk) begin
    if (!rst) begin
      if (irq_pulse) begin n_irq++; t_irq = cyc; end
      if (smi_pulse) begin n_smi++; t_smi = cyc; end
      if (reboot_req) begin n_rb++; t_rb = cyc; end
      if ((irq_pulse && p_irq) || (smi_pulse && p_smi) || (reboot_req && p_rb) ||
          (int'(irq_pulse) + int'(smi_pulse) + int'(reboot_req) > 1)) n_bad++;
    end
    p_irq = irq_pulse; p_smi = smi_pulse; p_rb = reboot_req;
  end

  always @(posedge clk) begin
    if (cyc > 150000) begin
      n_chk++; n_err++;
      $display("FAIL watchdog: run hung, actual cycle %0d expected below 150000", cyc);
      $display("  Result: errors=%0d of %0d checks", n_err, n_chk);
      $finish;
    end
  end

  function automatic longint dur(input longint p, input bit fast);
    if (p == 0) return 1;
    return fast ? (p << 5) : (p << 15);
  endfunction

  task automatic chk(input string req, input longint act, input longint exp);
    n_chk++;
    if (act != exp) begin
      n_err++;
      $display("FAIL %s: actual %0d expected %0d", req, act, exp);
    end
  endtask

  task automatic snap();
    b_irq = n_irq; b_smi = n_smi; b_rb = n_rb;
  endtask

  task automatic wait_until(input longint t);
    while (cyc < t) @(negedge clk);
  endtask

  task automatic do_ctl(input bit e, input bit l, input bit f);
    @(negedge clk);
    ctl_en = e; ctl_lock = l; ctl_free = f; ctl_we = 1;
    @(posedge clk); #1 wr_cyc = cyc;
    @(negedge clk) ctl_we = 0;
  endtask

  task automatic do_cfg(input bit nr, input bit fast, input logic [1:0] ty);
    @(negedge clk);
    cfg_no_reboot = nr; cfg_fast = fast; cfg_int_type = ty; cfg_we = 1;
    @(negedge clk) cfg_we = 0;
  endtask

  task automatic do_pl(input int which, input logic [19:0] v);
    @(negedge clk);
    pl_data = v;
    if (which == 1) pl1_we = 1; else pl2_we = 1;
    @(negedge clk) begin pl1_we = 0; pl2_we = 0; end
  endtask

  // sel: 0 keepalive, 1 flag_clr; captured at the edge that makes cyc == tgt
  task automatic strobe_at(input longint tgt, input int sel);
    while (cyc < tgt - 1) @(negedge clk);
    if (sel == 0) keepalive = 1; else flag_clr = 1;
    @(posedge clk); #1 wr_cyc = cyc;
    @(negedge clk) begin keepalive = 0; flag_clr = 0; end
  endtask

  task automatic do_reset();
    @(negedge clk) rst = 1;
    repeat (3) @(negedge clk);
    rst = 0;
  endtask

  initial begin
    longint c0, d1, d2, k;
    int seed;
    seed = $urandom(20240611);
    repeat (3) @(negedge clk);
    rst = 0;
    @(negedge clk);

    // R1 reset outputs
    chk("R1 outputs idle", {irq_pulse, smi_pulse, reboot_req, last_wd_reset}, 0);

    // R1 preload reset value is large: default slow, 0xFFFFF -> no expiry soon
    snap();
    do_ctl(1, 0, 0);
    wait_until(wr_cyc + 2000);
    chk("R1 default preload silent", n_irq - b_irq, 0);
    do_ctl(0, 0, 0);

    // R1 default type IRQ and reboot enabled; R2 zero preload lasts one cycle
    do_pl(1, 0); do_pl(2, 0);
    snap();
    do_ctl(1, 0, 0); c0 = wr_cyc;
    wait_until(c0 + 10);
    chk("R2 zero preload irq time", t_irq, c0 + 1);
    chk("R1 default irq type count", n_irq - b_irq, 1);
    chk("R1 default reboot enabled time", t_rb, c0 + 2);
    chk("R6 flag set", last_wd_reset, 1);
    chk("R6 stops after reboot", n_rb - b_rb, 1);

    // R12 clear
    strobe_at(cyc + 2, 1);
    @(negedge clk);
    chk("R12 flag cleared", last_wd_reset, 0);

    // R10 keepalive restarts after reboot; R12 set wins over clear
    snap();
    strobe_at(cyc + 2, 0); k = wr_cyc;
    strobe_at(k + 2, 1);
    @(negedge clk);
    chk("R10 restart after stop irq time", t_irq, k + 1);
    chk("R12 set beats clear", last_wd_reset, 1);
    do_ctl(0, 0, 0);
    strobe_at(cyc + 2, 1);

    // R2 slow prescale (default cfg), preload 1 -> 32768 cycles; R3 timing
    do_pl(1, 1);
    snap();
    do_ctl(1, 0, 0); c0 = wr_cyc;
    wait_until(c0 + 32768 + 3);
    chk("R2 slow stage time", t_irq, c0 + dur(1, 0));
    chk("R3 one irq", n_irq - b_irq, 1);
    do_ctl(0, 0, 0);

    // R10 keepalive priority on the expiry edge
    do_cfg(1, 1, 0); do_pl(1, 4); do_pl(2, 7);
    snap();
    do_ctl(1, 0, 0); c0 = wr_cyc;
    d1 = dur(4, 1);
    strobe_at(c0 + d1, 0);
    wait_until(c0 + 2 * d1 + 5);
    chk("R10 kick priority count", n_irq - b_irq, 1);
    chk("R10 kick priority time", t_irq, c0 + 2 * d1);
    do_ctl(0, 0, 0);

    // R11 keepalive while disabled
    snap();
    strobe_at(cyc + 3, 0);
    wait_until(cyc + 400);
    chk("R11 kick disabled no pulse", (n_irq - b_irq) + (n_smi - b_smi) + (n_rb - b_rb), 0);

    // R4 disable stops
    snap();
    do_ctl(1, 0, 0); c0 = wr_cyc;
    wait_until(c0 + 50);
    do_ctl(0, 0, 0);
    wait_until(c0 + 600);
    chk("R4 stopped no pulse", (n_irq - b_irq) + (n_smi - b_smi) + (n_rb - b_rb), 0);

    // R8 free run
    do_cfg(0, 1, 0); do_pl(1, 1); do_pl(2, 1);
    snap();
    do_ctl(1, 0, 1); c0 = wr_cyc;
    wait_until(c0 + 130);
    chk("R8 free run irqs", n_irq - b_irq, 2);
    chk("R8 free run reboots", n_rb - b_rb, 2);
    chk("R8 second irq time", t_irq, c0 + 96);
    do_ctl(0, 0, 0);
    strobe_at(cyc + 2, 1);

    // R5 SMI type, R7 no reboot and stop
    do_cfg(1, 1, 2);
    snap();
    do_ctl(1, 0, 0); c0 = wr_cyc;
    wait_until(c0 + 300);
    chk("R5 smi time", t_smi, c0 + 32);
    chk("R5 smi count", n_smi - b_smi, 1);
    chk("R7 no reboot", n_rb - b_rb, 0);
    chk("R7 flag unchanged", last_wd_reset, 0);
    do_ctl(0, 0, 0);

    // R9 lock freezes controls
    do_cfg(0, 1, 0); do_pl(1, 2); do_pl(2, 1);
    snap();
    do_ctl(1, 1, 0); c0 = wr_cyc;
    do_ctl(0, 0, 1);
    wait_until(c0 + 400);
    chk("R9 irq despite disable write", t_irq, c0 + 64);
    chk("R9 reboot once (no free run)", n_rb - b_rb, 1);
    chk("R9 reboot time", t_rb, c0 + 96);
    do_reset();
    @(negedge clk);
    chk("R1 flag cleared by reset", last_wd_reset, 0);

    // Random fast-mode runs
    for (int i = 0; i < 8; i++) begin
      longint p1, p2;
      int ty;
      bit nr;
      p1 = $urandom_range(0, 7); p2 = $urandom_range(0, 7);
      ty = $urandom_range(0, 3); nr = 1'($urandom_range(0, 1));
      do_ctl(0, 0, 0);
      strobe_at(cyc + 2, 1);
      do_cfg(nr, 1, 2'(ty)); do_pl(1, 20'(p1)); do_pl(2, 20'(p2));
      snap();
      do_ctl(1, 0, 0); c0 = wr_cyc;
      d1 = dur(p1, 1); d2 = dur(p2, 1);
      wait_until(c0 + 2 * (d1 + d2) + 8);
      chk("R5 rand irq count", n_irq - b_irq, (ty == 0) ? 1 : 0);
      chk("R5 rand smi count", n_smi - b_smi, (ty == 2) ? 1 : 0);
      if (ty == 0) chk("R3 rand irq time", t_irq, c0 + d1);
      if (ty == 2) chk("R5 rand smi time", t_smi, c0 + d1);
      if (!nr) begin
        chk("R6 rand reboot count", n_rb - b_rb, 1);
        chk("R6 rand reboot time", t_rb, c0 + d1 + d2);
        chk("R6 rand flag", last_wd_reset, 1);
      end else begin
        chk("R7 rand no reboot", n_rb - b_rb, 0);
        chk("R7 rand flag", last_wd_reset, 0);
      end
    end

    chk("R13 pulse shape violations", n_bad, 0);
    $display("  Result: errors=%0d of %0d checks", n_err, n_chk);
    $finish;
  end

endmodule